// File: doc/BRIEF.md
# Two-Step Egress Timestamp Reporter

This block sits on the transmit path of a precision-time-protocol capable MAC. It does two things. It carries the client's packet stream through a fixed-length register pipeline without changing it. It also reports when each marked frame left. The client marks a frame in its start-of-packet beat by raising a request line and presenting a fingerprint at the same time. The fingerprint is an opaque tag whose width is a parameter.

The fingerprints of requested frames wait in order in a small queue. When the start-of-packet beat of a requested frame reaches the output register, the block captures the current time of day and pairs it with the fingerprint at the head of the queue. It then raises a one-cycle valid. This lets software tie each departure time to the frame that caused it.

Two time-of-day inputs are accepted, one 96 bits wide and one 64 bits wide. Each drives its own report port with its own valid. Both reports carry the same fingerprint. Either report can be removed by a parameter. `PIPE_STAGES` must be at least 2, and `FIFO_DEPTH` must be at least `PIPE_STAGES`.

Top module: `egr_ts_reporter`

## Requirements
- R1: Every input beat (valid, start, end, data) appears unchanged on the output exactly `PIPE_STAGES` cycles after it was presented.
- R2: For a beat presented with in_valid_i=1, in_sop_i=1 and ts_req_i=1, ts96_valid_o is high in exactly the cycle that beat is on the output, and only for that one cycle.
- R3: The reported 96-bit time equals the value on tod96_i in the cycle just before the requested start beat appears on the output. This is the value sampled by the edge that moves the beat into the output register.
- R4: The fingerprint reported with each request equals the ts_fp_i value presented with that request, and reports come out in request order.
- R5: ts_req_i has no effect unless in_valid_i and in_sop_i are both high in the same cycle. Frames without a request produce no report.
- R6: The 64-bit report goes valid in the same cycles as the 96-bit report. It carries the same fingerprint and the tod64_i value sampled at the same edge.
- R7: While rst_ni is low, and until the first beat has crossed the pipeline, out_valid_o, ts96_valid_o and ts64_valid_o are low.
- R8: With FIFO_DEPTH at least PIPE_STAGES, an unbroken run of requested single-beat frames is reported in full with no fingerprint lost or repeated. The fingerprint queue never overflows or underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input beat valid |
| in_sop_i | input | 1 | Input beat starts a frame |
| in_eop_i | input | 1 | Input beat ends a frame |
| in_data_i | input | DATA_W | Input beat data |
| ts_req_i | input | 1 | Request a departure report for this frame (start beat only) |
| ts_fp_i | input | FP_W | Fingerprint paired with the request |
| tod96_i | input | 96 | Current 96-bit time of day |
| tod64_i | input | 64 | Current 64-bit time of day |
| out_valid_o | output | 1 | Output beat valid |
| out_sop_o | output | 1 | Output beat starts a frame |
| out_eop_o | output | 1 | Output beat ends a frame |
| out_data_o | output | DATA_W | Output beat data |
| ts96_valid_o | output | 1 | 96-bit report valid |
| ts96_o | output | 96 | 96-bit departure time |
| ts96_fp_o | output | FP_W | Fingerprint for the 96-bit report |
| ts64_valid_o | output | 1 | 64-bit report valid |
| ts64_o | output | 64 | 64-bit departure time |
| ts64_fp_o | output | FP_W | Fingerprint for the 64-bit report |

## Verification
The bench targets several corner cases, each with a distinct failure symptom:

- **Back-to-back requested single-beat frames.** These fill every pipeline stage and keep the queue at its highest level. A queue that is too shallow or mis-pointed would drop a fingerprint or repeat one.
- **Requests raised on idle cycles and on mid-frame beats.** A design that did not qualify the request with valid and start would emit extra reports and desynchronise every fingerprint after them.
- **Time-of-day ramp.** The time of day changes every cycle, so capturing it one cycle early or late shows up as a wrong value rather than passing unnoticed.
- **Fingerprint width.** The fingerprint is 12 bits, so truncating it to a byte would corrupt the upper nibble.

// File: rtl/egr_ts_pkg.sv
package egr_ts_pkg;
  localparam int TOD96_W = 96;
  localparam int TOD64_W = 64;

  typedef struct packed {
    logic vld;
    logic sop;
    logic eop;
    logic req;
  } beat_ctl_t;
endpackage

// File: rtl/egr_pipe.sv
module egr_pipe
  import egr_ts_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int STAGES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  beat_ctl_t         ctl_i,
  input  logic [DATA_W-1:0] data_i,
  output beat_ctl_t         ctl_o,
  output logic [DATA_W-1:0] data_o,
  output logic              depart_o
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    beat_ctl_t         ctl_d, ctl_r;
    logic [DATA_W-1:0] data_d, data_r;

    if (g == 0) begin : g_head
      assign ctl_d  = ctl_i;
      assign data_d = data_i;
    end else begin : g_body
      assign ctl_d  = g_stg[g-1].ctl_r;
      assign data_d = g_stg[g-1].data_r;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctl_r <= '0;
      else         ctl_r <= ctl_d;
    end

    always_ff @(posedge clk_i) data_r <= data_d;
  end

  assign ctl_o  = g_stg[STAGES-1].ctl_r;
  assign data_o = g_stg[STAGES-1].data_r;

  // beat about to enter the output register
  assign depart_o = g_stg[STAGES-1].ctl_d.vld & g_stg[STAGES-1].ctl_d.sop &
                    g_stg[STAGES-1].ctl_d.req;

  // R5: a request flag only ever travels on a valid start beat
  a_r5_req_on_sop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.req |-> (ctl_o.vld && ctl_o.sop));
endmodule

// File: rtl/egr_fp_fifo.sv
module egr_fp_fifo #(
  parameter int FP_W  = 8,
  parameter int DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [FP_W-1:0] fp_i,
  input  logic            pop_i,
  output logic [FP_W-1:0] head_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [FP_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             full, empty;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full   = (cnt == CNT_W'(DEPTH));
  assign empty  = (cnt == '0);
  assign head_o = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= fp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= bump(wr_ptr);
      if (pop_i)  rd_ptr <= bump(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R8: queue sized for the pipeline never overflows or underflows
  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && !pop_i && full));
  a_r8_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && empty));
endmodule

// File: rtl/egr_ts_report.sv
module egr_ts_report #(
  parameter int TOD_W = 96,
  parameter int FP_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             depart_i,
  input  logic [TOD_W-1:0] tod_i,
  input  logic [FP_W-1:0]  fp_i,
  output logic             valid_o,
  output logic [TOD_W-1:0] ts_o,
  output logic [FP_W-1:0]  fp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ts_o    <= '0;
      fp_o    <= '0;
    end else begin
      valid_o <= depart_i;
      if (depart_i) begin
        ts_o <= tod_i;
        fp_o <= fp_i;
      end
    end
  end
endmodule

// File: rtl/egr_ts_reporter.sv
module egr_ts_reporter
  import egr_ts_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int FP_W        = 12,
  parameter int PIPE_STAGES = 3,
  parameter int FIFO_DEPTH  = 4,
  parameter bit EN_96       = 1'b1,
  parameter bit EN_64       = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic               in_sop_i,
  input  logic               in_eop_i,
  input  logic [DATA_W-1:0]  in_data_i,
  input  logic               ts_req_i,
  input  logic [FP_W-1:0]    ts_fp_i,
  input  logic [TOD96_W-1:0] tod96_i,
  input  logic [TOD64_W-1:0] tod64_i,
  output logic               out_valid_o,
  output logic               out_sop_o,
  output logic               out_eop_o,
  output logic [DATA_W-1:0]  out_data_o,
  output logic               ts96_valid_o,
  output logic [TOD96_W-1:0] ts96_o,
  output logic [FP_W-1:0]    ts96_fp_o,
  output logic               ts64_valid_o,
  output logic [TOD64_W-1:0] ts64_o,
  output logic [FP_W-1:0]    ts64_fp_o
);
  beat_ctl_t       in_ctl, out_ctl;
  logic            take, depart;
  logic [FP_W-1:0] head_fp;

  assign take   = in_valid_i & in_sop_i & ts_req_i;
  assign in_ctl = '{vld: in_valid_i, sop: in_sop_i, eop: in_eop_i, req: take};

  egr_pipe #(.DATA_W(DATA_W), .STAGES(PIPE_STAGES)) u_pipe (
    .clk_i, .rst_ni,
    .ctl_i   (in_ctl),
    .data_i  (in_data_i),
    .ctl_o   (out_ctl),
    .data_o  (out_data_o),
    .depart_o(depart)
  );

  assign out_valid_o = out_ctl.vld;
  assign out_sop_o   = out_ctl.sop;
  assign out_eop_o   = out_ctl.eop;

  egr_fp_fifo #(.FP_W(FP_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(take),
    .fp_i  (ts_fp_i),
    .pop_i (depart),
    .head_o(head_fp)
  );

  if (EN_96) begin : g_r96
    egr_ts_report #(.TOD_W(TOD96_W), .FP_W(FP_W)) u_rep (
      .clk_i, .rst_ni,
      .depart_i(depart), .tod_i(tod96_i), .fp_i(head_fp),
      .valid_o(ts96_valid_o), .ts_o(ts96_o), .fp_o(ts96_fp_o)
    );
    // R2: a report only rides alongside an outgoing start beat
    a_r2_report_on_sop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ts96_valid_o |-> (out_valid_o && out_sop_o));
  end else begin : g_n96
    assign ts96_valid_o = 1'b0;
    assign ts96_o       = '0;
    assign ts96_fp_o    = '0;
  end

  if (EN_64) begin : g_r64
    egr_ts_report #(.TOD_W(TOD64_W), .FP_W(FP_W)) u_rep (
      .clk_i, .rst_ni,
      .depart_i(depart), .tod_i(tod64_i), .fp_i(head_fp),
      .valid_o(ts64_valid_o), .ts_o(ts64_o), .fp_o(ts64_fp_o)
    );
    a_r2_report64_on_sop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ts64_valid_o |-> (out_valid_o && out_sop_o));
  end else begin : g_n64
    assign ts64_valid_o = 1'b0;
    assign ts64_o       = '0;
    assign ts64_fp_o    = '0;
  end

  if (EN_96 && EN_64) begin : g_pair
    // R6: both reports fire together with one fingerprint
    a_r6_same_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ts96_valid_o == ts64_valid_o);
    a_r6_same_fp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ts96_valid_o |-> (ts96_fp_o == ts64_fp_o));
  end
endmodule

// File: tb/sim_egr_ts_reporter.sv
module sim_egr_ts_reporter;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 64;
  localparam int FP_W   = 12;
  localparam int LAT    = 3;
  localparam int HN     = 4096;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              in_valid_i, in_sop_i, in_eop_i, ts_req_i;
  logic [DATA_W-1:0] in_data_i;
  logic [FP_W-1:0]   ts_fp_i;
  logic [95:0]       tod96_i;
  logic [63:0]       tod64_i;
  logic              out_valid_o, out_sop_o, out_eop_o;
  logic [DATA_W-1:0] out_data_o;
  logic              ts96_valid_o, ts64_valid_o;
  logic [95:0]       ts96_o;
  logic [63:0]       ts64_o;
  logic [FP_W-1:0]   ts96_fp_o, ts64_fp_o;

  egr_ts_reporter #(.DATA_W(DATA_W), .FP_W(FP_W), .PIPE_STAGES(LAT), .FIFO_DEPTH(4)) u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int  n_chk = 0, n_bad = 0, cyc = 0;
  bit  done = 0, burst = 0;
  logic              h_vld [HN];
  logic              h_sop [HN];
  logic              h_eop [HN];
  logic              h_req [HN];
  logic [DATA_W-1:0] h_dat [HN];
  logic [FP_W-1:0]   h_fp  [HN];

  function automatic logic [95:0] tod96f(input int n);
    return {32'(n) ^ 32'h5A5A_0F0F, 32'(n) * 32'd7, 32'(n)};
  endfunction
  function automatic logic [63:0] tod64f(input int n);
    return {~32'(n), 32'(n) + 32'h100};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s cyc=%0d act=%h exp=%h", rq, what, cyc, act, exp);
    end
  endtask

  task automatic check_cycle(input int n);
    int  k;
    bit  ev, er;
    if (n < LAT) begin
      chk(!out_valid_o && !ts96_valid_o && !ts64_valid_o, "R7", "startup idle",
          {out_valid_o, ts96_valid_o, ts64_valid_o}, 0);
      return;
    end
    k  = (n - LAT) % HN;
    ev = h_vld[k];
    er = ev & h_sop[k] & h_req[k];
    chk(out_valid_o == ev, "R1", "out_valid", out_valid_o, ev);
    if (ev)
      chk(out_sop_o == h_sop[k] && out_eop_o == h_eop[k] && out_data_o == h_dat[k],
          "R1", "beat", {out_sop_o, out_eop_o, out_data_o}, {h_sop[k], h_eop[k], h_dat[k]});
    chk(ts96_valid_o == er, er ? "R2" : "R5", "ts96_valid", ts96_valid_o, er);
    chk(ts64_valid_o == er, "R6", "ts64_valid", ts64_valid_o, er);
    if (er) begin
      chk(ts96_o == tod96f(n - 1), "R3", "ts96", ts96_o, tod96f(n - 1));
      chk(ts96_fp_o == h_fp[k], burst ? "R8" : "R4", "fp96", ts96_fp_o, h_fp[k]);
      chk(ts64_o == tod64f(n - 1), "R6", "ts64", ts64_o, tod64f(n - 1));
      chk(ts64_fp_o == h_fp[k], "R6", "fp64", ts64_fp_o, h_fp[k]);
    end
  endtask

  task automatic step(input bit v, input bit s, input bit e, input bit r,
                      input logic [FP_W-1:0] fp, input logic [DATA_W-1:0] d);
    int k;
    check_cycle(cyc);
    k = cyc % HN;
    in_valid_i = v; in_sop_i = s; in_eop_i = e; ts_req_i = r;
    ts_fp_i = fp; in_data_i = d;
    tod96_i = tod96f(cyc); tod64_i = tod64f(cyc);
    h_vld[k] = v; h_sop[k] = s; h_eop[k] = e; h_req[k] = r;
    h_dat[k] = d; h_fp[k] = fp;
    @(negedge clk_i);
    cyc++;
  endtask

  function automatic logic [DATA_W-1:0] rnd_data();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    bit in_pkt;
    int rem;
    void'($urandom(32'd4242));
    rst_ni = 1'b0;
    in_valid_i = 0; in_sop_i = 0; in_eop_i = 0; ts_req_i = 0;
    ts_fp_i = '0; in_data_i = '0; tod96_i = '0; tod64_i = '0;
    repeat (3) begin
      @(negedge clk_i);
      chk(!out_valid_o && !ts96_valid_o && !ts64_valid_o, "R7", "reset outputs",
          {out_valid_o, ts96_valid_o, ts64_valid_o}, 0);
    end
    rst_ni = 1'b1;

    // R8: back-to-back requested single-beat frames
    burst = 1;
    for (int i = 0; i < LAT + 3; i++) step(1, 1, 1, 1, FP_W'(12'hA00 + i), rnd_data());
    step(0, 0, 0, 0, '0, '0);
    for (int i = 0; i < LAT; i++) step(0, 0, 0, 0, '0, '0);
    burst = 0;
    // R5: request on idle cycle and on mid-frame beats
    step(0, 1, 0, 1, 12'hBAD, rnd_data());
    step(1, 1, 0, 0, 12'h111, rnd_data());
    step(1, 0, 0, 1, 12'hBAD, rnd_data());
    step(1, 0, 1, 1, 12'hBAD, rnd_data());
    step(1, 1, 0, 1, 12'hFED, rnd_data());
    step(1, 0, 1, 0, 12'h000, rnd_data());

    in_pkt = 0; rem = 0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(3) == 0) begin
        step(0, 1'($urandom()), 1'($urandom()), 1'($urandom()), FP_W'($urandom()), rnd_data());
      end else if (!in_pkt) begin
        rem = 1 + $urandom_range(3);
        step(1, 1, rem == 1, 1'($urandom()), FP_W'($urandom()), rnd_data());
        rem--;
        in_pkt = (rem != 0);
      end else begin
        step(1, 0, rem == 1, 1'($urandom()), FP_W'($urandom()), rnd_data());
        rem--;
        in_pkt = (rem != 0);
      end
    end
    for (int i = 0; i < LAT + 2; i++) step(0, 0, 0, 0, '0, '0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog cyc=%0d act=%0d exp=%0d", cyc, 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule